// File: doc/BRIEF.md
# Multi-level interrupt priority resolver

The resolver picks one interrupt to hand to a processor from seven maskable sources and one power-fail warning. The maskable sources, by bit index 0 to 6, are external interrupt 0, timer 0, external interrupt 1, timer 1, serial port 0, timer 2 and serial port 1. Each source's two-bit level is split across two byte-wide registers on a small register bus. The register at address B1h holds the upper level bit and the register at address B8h holds the lower level bit. Bit n of each register belongs to source n. The power-fail warning always sits on a fifth level, above all four programmable ones.

The block keeps one in-service flag for each of levels 0 to 4. A request is granted only when its level is strictly above the highest level in service, so a more urgent source can nest over a less urgent handler. A grant appears as a one-cycle `vec_valid` pulse, carrying the source index and its level. The processor signals the end of a handler with a one-cycle `reti` pulse, which retires the highest in-service level.

The two external pins are active low and pass through a two-flop synchronizer. Each pin can be run in falling-edge mode or in low-level mode. The five on-chip sources arrive as synchronous, active-high levels. Every source is treated as enabled.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the B1h register reads 0x80, the B8h register reads 0x00 and `vec_valid` is low. No level is in service, so a level-0 request is granted.
- R2: Writes with `bus_we` high update the addressed register. Bit 7 at B1h always reads 1 and ignores writes, while all 8 bits at B8h are stored. Any other address reads 0x00 and writes to it change neither register.
- R3: The level of source n is {B1h bit n, B8h bit n}, giving 0 to 3. The pending source with the highest level wins.
- R4: Among pending sources of equal level, the lowest index wins.
- R5: When the power-fail request is high it wins, with `vec_idx` = 7 and `vec_level` = 4. This includes preempting a level-3 handler.
- R6: A grant happens only if the winner's level is strictly greater than the highest in-service level. It is reported by `vec_valid` high for the one cycle after the deciding clock edge, and it marks that level as in service.
- R7: A `reti` pulse clears the highest in-service level. A grant decided in the same cycle is compared against the level left after that clearing.
- R8: With `ext_edge[k]` = 1, a falling edge on `ext_pin_n[k]` is latched after synchronization and stays pending until that source is granted. One edge yields exactly one grant, even while the pin stays low.
- R9: With `ext_edge[k]` = 0, the source is pending exactly while the synchronized pin is low. A pin still held low is granted again after its handler returns, and a released pin is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_pin_n | input | 2 | External interrupt pins, active low; bit 0 is source 0 and bit 1 is source 2 |
| ext_edge | input | 2 | Per pin: 1 = falling-edge mode, 0 = low-level mode |
| periph_req | input | 5 | On-chip requests, active high, for sources 1, 3, 4, 5, 6 in bit order 0..4 |
| pfail_req | input | 1 | Power-fail warning request, active high |
| reti | input | 1 | One-cycle return-from-handler pulse |
| vec_valid | output | 1 | One-cycle grant pulse |
| vec_idx | output | 3 | Granted source, 0..6, or 7 for power-fail |
| vec_level | output | 3 | Level of the granted source, 0..4 |

## Verification
The return pulse and a new grant can fall in the same cycle, and the order between them is the point of R7. The bench provokes this case on purpose. It parks a power-fail handler, raises a pattern of requests that cannot pass it, and then pulses `reti`. The grant must appear in the very next cycle and name the source the bench's own max-level, lowest-index search predicts. The bench sweeps 127 request masks, each with its own computed level assignment.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NSRC      = 7;
    localparam int NLVL      = 5;
    localparam int LVLW      = $clog2(NLVL);
    localparam int IDXW      = $clog2(NSRC + 1);
    localparam int PFAIL_IDX = NSRC;
    localparam int PFAIL_LVL = NLVL - 1;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic              latch;
    } st_t;

    st_t st_d, st_q;
    logic synced;
    logic fall;

    always_comb begin
        st_d      = st_q;
        synced    = st_q.sync[STAGES-1];
        st_d.sync = {st_q.sync[STAGES-2:0], pin_n};
        st_d.prev = synced;
        fall      = st_q.prev & ~synced;
        if (edge_mode) begin
            st_d.latch = fall | (st_q.latch & ~clr);
        end else begin
            st_d.latch = 1'b0;
        end
        pend = edge_mode ? st_q.latch : ~synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, prev: 1'b1, latch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
    parameter int            NSRC    = 7,
    parameter int            AW      = 8,
    parameter int            DW      = 8,
    parameter logic [AW-1:0] HI_ADDR = 8'hB1,
    parameter logic [AW-1:0] LO_ADDR = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NSRC-1:0] hi_bits,
    output logic [NSRC-1:0] lo_bits
);
    localparam int RSV = DW - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] hi;
        logic [DW-1:0]   lo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_we && bus_addr == HI_ADDR) begin
            st_d.hi = bus_wdata[NSRC-1:0];
        end
        if (bus_we && bus_addr == LO_ADDR) begin
            st_d.lo = bus_wdata;
        end
        if (bus_addr == HI_ADDR) begin
            bus_rdata = {{RSV{1'b1}}, st_q.hi};
        end else if (bus_addr == LO_ADDR) begin
            bus_rdata = st_q.lo;
        end else begin
            bus_rdata = '0;
        end
        hi_bits = st_q.hi;
        lo_bits = st_q.lo[NSRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_prio_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] hi_bits,
    input  logic [NSRC-1:0] lo_bits,
    input  logic            pfail,
    input  logic            ceil_any,
    input  logic [LVLW-1:0] ceil_lvl,
    output logic            win,
    output logic [IDXW-1:0] win_idx,
    output logic [LVLW-1:0] win_lvl
);
    logic            found;
    logic [LVLW-1:0] lv;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        lv      = '0;
        // scan downward with >= so that the lowest index keeps a tie
        for (int i = NSRC - 1; i >= 0; i--) begin
            lv = LVLW'({hi_bits[i], lo_bits[i]});
            if (pend[i] && (!found || lv >= win_lvl)) begin
                found   = 1'b1;
                win_idx = IDXW'(i);
                win_lvl = lv;
            end
        end
        if (pfail) begin
            found   = 1'b1;
            win_idx = IDXW'(PFAIL_IDX);
            win_lvl = LVLW'(PFAIL_LVL);
        end
        win = found && (!ceil_any || win_lvl > ceil_lvl);
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reti,
    input  logic            set,
    input  logic [LVLW-1:0] set_lvl,
    output logic            ceil_any,
    output logic [LVLW-1:0] ceil_lvl,
    output logic [NLVL-1:0] levels_busy
);
    typedef struct packed {
        logic [NLVL-1:0] isv;
    } st_t;

    st_t st_d, st_q;
    logic [NLVL-1:0] cleared;
    logic [LVLW-1:0] top;

    always_comb begin
        top = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (st_q.isv[l]) top = LVLW'(l);
        end
        cleared = st_q.isv;
        if (reti && st_q.isv != '0) begin
            cleared[top] = 1'b0;
        end
        ceil_any = (cleared != '0);
        ceil_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (cleared[l]) ceil_lvl = LVLW'(l);
        end
        st_d.isv = cleared;
        if (set) begin
            st_d.isv[set_lvl] = 1'b1;
        end
        levels_busy = st_q.isv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter logic [7:0] HI_ADDR     = 8'hB1,
    parameter logic [7:0] LO_ADDR     = 8'hB8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [1:0]      ext_pin_n,
    input  logic [1:0]      ext_edge,
    input  logic [NSRC-3:0] periph_req,
    input  logic            pfail_req,
    input  logic            reti,
    output logic            vec_valid,
    output logic [IDXW-1:0] vec_idx,
    output logic [LVLW-1:0] vec_level
);
    localparam int EXT_POS0 = 0;
    localparam int EXT_POS1 = 2;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
        logic [LVLW-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] hi_bits, lo_bits, pend;
    logic [1:0]      ext_pend, ext_clr;
    logic            win, ceil_any;
    logic [IDXW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl, ceil_lvl;
    logic [NLVL-1:0] levels_busy;

    irq_prio_regs #(
        .NSRC(NSRC), .AW(AW), .DW(DW), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hi_bits(hi_bits), .lo_bits(lo_bits)
    );

    assign ext_clr[0] = win && win_idx == IDXW'(EXT_POS0);
    assign ext_clr[1] = win && win_idx == IDXW'(EXT_POS1);

    for (genvar k = 0; k < 2; k++) begin : g_ext
        irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[k]),
            .edge_mode(ext_edge[k]), .clr(ext_clr[k]), .pend(ext_pend[k])
        );
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_map
        if (i == EXT_POS0) begin : g_x0
            assign pend[i] = ext_pend[0];
        end else if (i == EXT_POS1) begin : g_x1
            assign pend[i] = ext_pend[1];
        end else if (i < EXT_POS1) begin : g_lo
            assign pend[i] = periph_req[i-1];
        end else begin : g_hi
            assign pend[i] = periph_req[i-2];
        end
    end

    irq_pick u_pick (
        .pend(pend), .hi_bits(hi_bits), .lo_bits(lo_bits), .pfail(pfail_req),
        .ceil_any(ceil_any), .ceil_lvl(ceil_lvl),
        .win(win), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_inservice u_isv (
        .clk(clk), .rst_n(rst_n), .reti(reti), .set(win), .set_lvl(win_lvl),
        .ceil_any(ceil_any), .ceil_lvl(ceil_lvl), .levels_busy(levels_busy)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = win;
        if (win) begin
            st_d.idx = win_idx;
            st_d.lvl = win_lvl;
        end
        vec_valid = st_q.valid;
        vec_idx   = st_q.idx;
        vec_level = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter logic [7:0] HI_ADDR = 8'hB1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      bus_addr,
    input logic [7:0]      bus_rdata,
    input logic            pfail_req,
    input logic            reti,
    input logic            vec_valid,
    input logic [IDXW-1:0] vec_idx,
    input logic [LVLW-1:0] vec_level,
    input logic [NLVL-1:0] levels_busy
);
    a_r2_reserved_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == HI_ADDR) |-> bus_rdata[7]);

    a_r5_pfail_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_idx == IDXW'(PFAIL_IDX)) |-> $past(pfail_req));

    a_r5_pfail_level: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_idx == IDXW'(PFAIL_IDX)) |-> vec_level == LVLW'(PFAIL_LVL));

    a_r6_grant_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((levels_busy >> vec_level) == NLVL'(1)));

    a_r7_return_count: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && levels_busy != '0) |=>
        ($countones(levels_busy) == $past($countones(levels_busy)) - 1 + int'(vec_valid)));
endmodule

bind irq_prio_arbiter irq_prio_chk #(.HI_ADDR(HI_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pfail_req(pfail_req), .reti(reti), .vec_valid(vec_valid),
    .vec_idx(vec_idx), .vec_level(vec_level), .levels_busy(levels_busy)
);

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge = 2'b00;
    logic [4:0] periph_req = 5'b0;
    logic       pfail_req = 1'b0;
    logic       reti = 1'b0;
    logic       vec_valid;
    logic [2:0] vec_idx;
    logic [2:0] vec_level;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin_n(ext_pin_n),
        .ext_edge(ext_edge), .periph_req(periph_req), .pfail_req(pfail_req),
        .reti(reti), .vec_valid(vec_valid), .vec_idx(vec_idx), .vec_level(vec_level)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        tick();
        reti = 1'b0;
    endtask

    // counts grant pulses over n cycles, remembering the last one
    task automatic watch(input int n, output int cnt, output int idx, output int lvl);
        cnt = 0; idx = -1; lvl = -1;
        for (int c = 0; c < n; c++) begin
            tick();
            if (vec_valid) begin
                cnt++; idx = int'(vec_idx); lvl = int'(vec_level);
            end
        end
    endtask

    // runs until the first grant pulse, at most n cycles
    task automatic wait_grant(input int n, output int idx, output int lvl);
        idx = -1; lvl = -1;
        for (int c = 0; c < n; c++) begin
            tick();
            if (vec_valid) begin
                idx = int'(vec_idx); lvl = int'(vec_level);
                break;
            end
        end
    endtask

    function automatic int lvl_of(input int m, input int i);
        return (m * 5 + i * 3 + (m >> 3)) & 3;
    endfunction

    initial begin
        logic [7:0] rv;
        int cnt, idx, lvl;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(8'hB1, rv); chk(rv == 8'h80, "R1 hi reset", rv, 8'h80);
        rd(8'hB8, rv); chk(rv == 8'h00, "R1 lo reset", rv, 8'h00);
        chk(vec_valid == 1'b0, "R1 no grant", vec_valid, 0);

        // R2 register access
        wr(8'hB1, 8'hFF); rd(8'hB1, rv); chk(rv == 8'hFF, "R2 hi all ones", rv, 8'hFF);
        wr(8'hB1, 8'h00); rd(8'hB1, rv); chk(rv == 8'h80, "R2 reserved bit", rv, 8'h80);
        wr(8'hB8, 8'hA5); rd(8'hB8, rv); chk(rv == 8'hA5, "R2 lo stored", rv, 8'hA5);
        wr(8'h42, 8'h3C); rd(8'h42, rv); chk(rv == 8'h00, "R2 other addr", rv, 0);
        rd(8'hB1, rv); chk(rv == 8'h80, "R2 other write hi", rv, 8'h80);
        rd(8'hB8, rv); chk(rv == 8'hA5, "R2 other write lo", rv, 8'hA5);
        wr(8'hB8, 8'h00);

        // R1 idle state grants level 0; R9 level mode regrant
        ext_edge = 2'b00;
        ext_pin_n[1] = 1'b0;
        wait_grant(8, idx, lvl);
        chk(idx == 2 && lvl == 0, "R1 level0 from idle", idx, 2);
        pulse_reti();
        chk(vec_valid && vec_idx == 2, "R9 held low regrant", vec_idx, 2);
        ext_pin_n[1] = 1'b1;
        repeat (4) tick();
        pulse_reti();
        watch(5, cnt, idx, lvl);
        chk(cnt == 0, "R9 released no grant", cnt, 0);

        // R8 edge mode: short pulse gives one grant
        ext_edge = 2'b01;
        repeat (4) tick();
        ext_pin_n[0] = 1'b0; tick(); ext_pin_n[0] = 1'b1;
        watch(10, cnt, idx, lvl);
        chk(cnt == 1 && idx == 0, "R8 one edge one grant", cnt, 1);
        pulse_reti();
        ext_pin_n[0] = 1'b0;
        watch(10, cnt, idx, lvl);
        chk(cnt == 1, "R8 held low single grant", cnt, 1);
        pulse_reti();
        watch(6, cnt, idx, lvl);
        chk(cnt == 0, "R8 no regrant after return", cnt, 0);
        ext_pin_n[0] = 1'b1;
        repeat (4) tick();
        // R8 edge latched while blocked by power-fail
        pfail_req = 1'b1;
        wait_grant(5, idx, lvl);
        pfail_req = 1'b0;
        ext_pin_n[0] = 1'b0; tick(); ext_pin_n[0] = 1'b1;
        repeat (6) tick();
        pulse_reti();
        chk(vec_valid && vec_idx == 0, "R8 latched edge kept", vec_idx, 0);
        pulse_reti();
        ext_edge = 2'b00;
        repeat (4) tick();

        // R6 nesting: idx1 lvl1, idx3 lvl2, idx4 lvl1
        wr(8'hB1, 8'b0000_1000);
        wr(8'hB8, 8'b0001_0010);
        periph_req[0] = 1'b1;
        wait_grant(5, idx, lvl);
        chk(idx == 1 && lvl == 1, "R6 first grant", idx, 1);
        periph_req[2] = 1'b1;
        watch(4, cnt, idx, lvl);
        chk(cnt == 0, "R6 equal level blocked", cnt, 0);
        periph_req[1] = 1'b1;
        wait_grant(5, idx, lvl);
        chk(idx == 3 && lvl == 2, "R6 higher preempts", idx, 3);
        periph_req[1] = 1'b0;
        pulse_reti();
        chk(vec_valid == 1'b0, "R7 back at level1 blocks", vec_valid, 0);
        periph_req = 5'b0;
        pulse_reti();
        periph_req[2] = 1'b1;
        wait_grant(5, idx, lvl);
        chk(idx == 4 && lvl == 1, "R7 level1 retired", idx, 4);
        periph_req = 5'b0;
        pulse_reti();

        // R5 power-fail over level 3
        wr(8'hB1, 8'b0001_0000);
        wr(8'hB8, 8'b0001_0000);
        periph_req[2] = 1'b1;
        wait_grant(5, idx, lvl);
        chk(idx == 4 && lvl == 3, "R5 level3 grant", idx, 4);
        pfail_req = 1'b1;
        wait_grant(5, idx, lvl);
        chk(idx == 7 && lvl == 4, "R5 pfail preempts", idx, 7);
        pfail_req = 1'b0;
        periph_req = 5'b0;
        pulse_reti();
        pulse_reti();
        repeat (2) tick();

        // R3 R4 R7 sweep over request masks
        for (int m = 1; m < 128; m++) begin
            logic [7:0] hb, lb;
            int ei, el;
            hb = 8'h00; lb = 8'h00; ei = -1; el = -1;
            for (int i = 0; i < 7; i++) begin
                hb[i] = lvl_of(m, i)[1];
                lb[i] = lvl_of(m, i)[0];
                if (m[i] && lvl_of(m, i) > el) begin
                    el = lvl_of(m, i); ei = i;
                end
            end
            wr(8'hB1, hb);
            wr(8'hB8, lb);
            pfail_req = 1'b1;
            wait_grant(5, idx, lvl);
            pfail_req = 1'b0;
            chk(idx == 7, "R5 sweep pfail", idx, 7);
            ext_pin_n[0] = ~m[0];
            ext_pin_n[1] = ~m[2];
            periph_req = {m[6], m[5], m[4], m[3], m[1]};
            repeat (4) tick();
            reti = 1'b1;
            tick();
            reti = 1'b0;
            chk(vec_valid && int'(vec_idx) == ei && int'(vec_level) == el,
                "R3 R4 R7 sweep winner", int'(vec_idx), ei);
            watch(3, cnt, idx, lvl);
            chk(cnt == 0, "R6 sweep no extra grant", cnt, 0);
            ext_pin_n = 2'b11;
            periph_req = 5'b0;
            repeat (4) tick();
            pulse_reti();
            tick();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule